// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the array address for every cycle of a synchronous burst SRAM access. An external address is captured when either of two address strobes is asserted while the load is enabled. On later cycles, an advance input steps only the low burst bits of that address. The upper bits stay fixed for the whole burst.

A static order input picks the stepping rule. Linear order adds the beat number to the starting low bits, modulo the burst length. Interleaved order XORs the starting low bits with the beat number. Bursting is optional, so a fresh external address can be loaded on every cycle with no lost cycle.

The address is held in registers and shown on `addr_o` from the edge after the command that changed it. All pins are plain control and data pins. The block has no stream interface, so there is no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no command, `addr_o` reads zero.
- R2: When `strobe_host_i` and `sel_i` are high at a rising edge, `addr_o` equals the `addr_i` value sampled at that edge from that edge on. This also starts a new burst at beat 0.
- R3: When `strobe_ctrl_i` and `sel_i` are high at a rising edge, the load happens exactly as in R2.
- R4: A strobe seen while `sel_i` is low causes no load. If `advance_i` is also low, `addr_o` keeps its value.
- R5: In linear order (`order_i` = 0), each edge with `advance_i` high and no load sets the low BURST_W bits to (start + n) mod 2^BURST_W. Here n is the number of advances since the load, and the upper bits do not change.
- R6: In interleaved order (`order_i` = 1), each such advance sets the low bits to start XOR n, and the upper bits do not change.
- R7: With no strobe and `advance_i` low, `addr_o` holds its value.
- R8: If a strobe load and `advance_i` occur at the same edge, the load wins and `addr_o` shows `addr_i` unchanged.
- R9: After 2^BURST_W advances, the address is back at the burst's starting address, in either order.
- R10: Loads on consecutive cycles each take effect, with one new address per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset (synchronous) |
| addr_i | input | ADDR_W | External address to load |
| strobe_host_i | input | 1 | First address strobe |
| strobe_ctrl_i | input | 1 | Second address strobe |
| sel_i | input | 1 | Load enable that gates both strobes |
| advance_i | input | 1 | Step to the next burst beat |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current array address |

## Verification
The bench builds the block with ADDR_W = 12 and the default BURST_W = 2. The narrow address keeps the upper bits short enough to write expected values as hex literals while still showing that they stay fixed. With a four-beat burst, a full wrap back to the start takes only a few cycles. That makes every linear and interleaved sequence reachable from a mid-range start: start 2 is used for linear order and start 1 for interleaved order.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_ADVANCE = 2'd2
  } burst_act_e;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_addr_pkg::*;
(
  input  logic       strobe_host_i,
  input  logic       strobe_ctrl_i,
  input  logic       sel_i,
  input  logic       advance_i,
  output burst_act_e act_o
);
  logic load_req;

  always_comb begin
    load_req = (strobe_host_i | strobe_ctrl_i) & sel_i;
    if (load_req)       act_o = ACT_LOAD;
    else if (advance_i) act_o = ACT_ADVANCE;
    else                act_o = ACT_HOLD;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_addr_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  burst_act_e         act_i,
  input  logic [BURST_W-1:0] start_i,
  output logic [BURST_W-1:0] start_o,
  output logic [BURST_W-1:0] beat_o
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o <= '0;
      beat_o  <= '0;
    end else begin
      case (act_i)
        ACT_LOAD: begin
          start_o <= start_i;
          beat_o  <= '0;
        end
        ACT_ADVANCE: beat_o <= beat_o + ONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  burst_order_e       order_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] ilv_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_host_i,
  input  logic              strobe_ctrl_i,
  input  logic              sel_i,
  input  logic              advance_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  burst_act_e         act;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] low;
  logic [HI_W-1:0]    upper_q;
  burst_order_e       order;

  assign order = burst_order_e'(order_i);

  burst_cmd_decode u_dec (
    .strobe_host_i (strobe_host_i),
    .strobe_ctrl_i (strobe_ctrl_i),
    .sel_i         (sel_i),
    .advance_i     (advance_i),
    .act_o         (act)
  );

  burst_beat_counter #(.BURST_W(BURST_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .start_i (addr_i[BURST_W-1:0]),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .order_i (order),
    .start_i (start_q),
    .beat_i  (beat_q),
    .low_o   (low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                upper_q <= '0;
    else if (act == ACT_LOAD)  upper_q <= addr_i[ADDR_W-1:BURST_W];
  end

  assign addr_o = {upper_q, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_host_i,
  input logic              strobe_ctrl_i,
  input logic              sel_i,
  input logic              advance_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [BURST_W-1:0] low_now;
  logic               any_load;

  assign low_now  = addr_o[BURST_W-1:0];
  assign any_load = (strobe_host_i | strobe_ctrl_i) & sel_i;

  a_r2_load_host: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_host_i && sel_i) |=> addr_o == $past(addr_i));

  a_r3_load_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ctrl_i && sel_i) |=> addr_o == $past(addr_i));

  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && !advance_i) |=> $stable(addr_o));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_host_i && !strobe_ctrl_i && !advance_i) |=> $stable(addr_o));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !any_load && !order_i) |=>
      low_now == BURST_W'($past(low_now) + BURST_W'(1)));

  a_r6_ilv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !any_load && order_i) |=> low_now != $past(low_now));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !any_load) |=>
      $stable(addr_o[ADDR_W-1:BURST_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_i        (addr_i),
  .strobe_host_i (strobe_host_i),
  .strobe_ctrl_i (strobe_ctrl_i),
  .sel_i         (sel_i),
  .advance_i     (advance_i),
  .order_i       (order_i),
  .addr_o        (addr_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          sh, sc, sel, adv, ord;
  logic [AW-1:0] addr_o;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) dut (
    .clk (clk), .rst_n (rst_n), .addr_i (addr_i),
    .strobe_host_i (sh), .strobe_ctrl_i (sc), .sel_i (sel),
    .advance_i (adv), .order_i (ord), .addr_o (addr_o)
  );

  task automatic check(input logic [AW-1:0] exp, input string tag);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the rising edge
  task automatic step(input logic h, input logic c, input logic s,
                      input logic a, input logic [AW-1:0] ad);
    @(negedge clk);
    sh = h; sc = c; sel = s; adv = a; addr_i = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 0; sh = 0; sc = 0; sel = 0; adv = 0; ord = 0; addr_i = '0;
    repeat (3) @(posedge clk);
    #1 check('0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 12'hFFF);
    check('0, "R1 after release");
  endtask

  task automatic t_load_host;
    step(1, 0, 1, 0, 12'h123);
    check(12'h123, "R2 host strobe load");
  endtask

  task automatic t_load_ctrl;
    step(0, 1, 1, 0, 12'h8AB);
    check(12'h8AB, "R3 ctrl strobe load");
  endtask

  task automatic t_gate;
    step(1, 1, 0, 0, 12'h777);
    check(12'h8AB, "R4 strobe ignored when sel low");
  endtask

  task automatic t_linear;
    ord = 0;
    step(1, 0, 1, 0, 12'hA56);
    check(12'hA56, "R5 linear start");
    step(0, 0, 1, 1, 12'h000); check(12'hA57, "R5 linear beat1");
    step(0, 0, 1, 1, 12'h000); check(12'hA54, "R5 linear beat2 wrap mod4");
    step(0, 0, 1, 1, 12'h000); check(12'hA55, "R5 linear beat3");
    step(0, 0, 1, 1, 12'h000); check(12'hA56, "R9 linear back to start");
  endtask

  task automatic t_interleave;
    ord = 1;
    step(0, 1, 1, 0, 12'h3C5);
    check(12'h3C5, "R6 ilv start");
    step(0, 0, 1, 1, 12'hFFF); check(12'h3C4, "R6 ilv beat1");
    step(0, 0, 1, 1, 12'hFFF); check(12'h3C7, "R6 ilv beat2");
    step(0, 0, 1, 1, 12'hFFF); check(12'h3C6, "R6 ilv beat3");
    step(0, 0, 1, 1, 12'hFFF); check(12'h3C5, "R9 ilv back to start");
  endtask

  task automatic t_hold;
    step(0, 0, 1, 1, 12'h000); // 3C4
    step(0, 0, 1, 0, 12'h999);
    check(12'h3C4, "R7 hold cycle 1");
    step(0, 0, 0, 0, 12'h555);
    check(12'h3C4, "R7 hold cycle 2");
    step(0, 0, 1, 1, 12'h000);
    check(12'h3C7, "R7 count resumes after hold");
  endtask

  task automatic t_priority;
    ord = 0;
    step(1, 0, 1, 1, 12'h4E3);
    check(12'h4E3, "R8 load beats advance");
    step(0, 0, 1, 1, 12'h000);
    check(12'h4E0, "R8 next advance starts at beat1");
  endtask

  task automatic t_b2b;
    step(1, 0, 1, 0, 12'h101); check(12'h101, "R10 b2b load 1");
    step(0, 1, 1, 1, 12'h202); check(12'h202, "R10 b2b load 2");
    step(1, 1, 1, 0, 12'h303); check(12'h303, "R10 b2b load 3");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_load_host();
    t_load_ctrl();
    t_gate();
    t_linear();
    t_interleave();
    t_hold();
    t_priority();
    t_b2b();
    summary();
    $finish;
  end
endmodule